// File: doc/BRIEF.md
# Tag-Renaming Dynamic Instruction Scheduler

This block accepts an in-order stream of register-to-register arithmetic instructions and lets them run out of order on a small pool of holding slots. Each slot belongs to one execution class: adder slots take add and subtract, multiplier slots take multiply. At issue, every destination register is renamed to the tag of the slot that will produce it. Each source operand is read either as a value or as the tag it is waiting for. A later instruction that writes a register an earlier one still reads therefore never waits. The same holds for two writers of one register.

Each slot runs through four named states. FREE goes to WAIT on allocation. WAIT goes to EXEC once both operand values are held. EXEC goes to DONE when the fixed-latency countdown reaches zero. DONE goes back to FREE when the slot wins the single result bus. Every cycle, one winner drives its tag and value on the result bus. Waiting slots take the value when the tag matches. A register whose pending tag still matches is written and marked ready. The register file starts with register i holding the value i. A read port shows any register and whether it still waits on a producer.

Top module: `rs_sched`

## Requirements
- R1: After reset every slot is FREE, no result is on the bus, every register i reads the value i and no register is pending.
- R2: Op codes are 0 = add, 1 = subtract (src1 - src2), 2 = multiply (low 16 bits). An instruction issues on a clock edge where iss_valid is high and a FREE slot of its class exists (iss_ready high). Otherwise the request is ignored and has no effect on any register.
- R3: At issue a ready source is copied as a value. A pending source is held as its producer's tag. The destination becomes pending on the new slot's tag until that tag is broadcast.
- R4: A slot leaves WAIT only when both operands hold values. With operands ready at issue, its result reaches the bus LAT+1 cycles after the issue edge, where LAT is 2 for adder slots and 4 for multiplier slots.
- R5: A slot in WAIT whose operand tag equals the broadcast tag takes the broadcast value for that operand.
- R6: While a slot broadcasts, the bus shows its tag (adder slots 1..3, multiplier slots 4..5) and its result. A register whose pending tag matches is written with that value and is no longer pending.
- R7: When a newer instruction has renamed a register, an older broadcast to that register leaves it unchanged. The register ends with the newest value in program order.
- R8: A later writer of a register that an earlier, still waiting instruction reads does not stall, and the earlier instruction still uses the old value.
- R9: At most one result uses the bus per cycle. Among DONE slots the lowest tag wins, and the others stay DONE until they win.
- R10: A source whose producer broadcasts in the same cycle as the consumer issues is taken from the bus, not recorded as a tag.
- R11: A slot that broadcasts in a cycle is FREE in the next cycle, not in the cycle of the broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_op | input | 2 | Operation: 0 add, 1 subtract, 2 multiply |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_ready | output | 1 | A FREE slot of the offered op's class exists |
| bus_valid | output | 1 | A result is broadcast this cycle |
| bus_tag | output | 3 | Tag of the broadcasting slot |
| bus_data | output | 16 | Broadcast result value |
| rd_idx | input | 3 | Register read address |
| rd_data | output | 16 | Register file value at rd_idx |
| rd_pending | output | 1 | Register at rd_idx waits on a producer |

## Verification
The assertions assume that iss_op never carries the unused code 3. They also assume that reset is held for at least one edge before the first issue, so every slot starts FREE and no tag is pending. The stimulus uses only codes 0 to 2. It applies reset at the start of every directed sequence and presents an instruction only after sampling iss_ready. The single exception is the deliberate ignored-request case, which is held only on edges where iss_ready is low.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_FREE,
        ST_WAIT,
        ST_EXEC,
        ST_DONE
    } slot_st_e;

endpackage

// File: rtl/rs_prio_arb.sv
module rs_prio_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    // R9: exactly one winner whenever anyone asks, and never a non-requester
    p_single_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ($onehot(grant) && ((grant & ~req) == '0)));

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_sched_pkg::*;
#(
    parameter int W   = 16,
    parameter int TW  = 3,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  op_e           a_op,
    input  logic [W-1:0]  a_vj,
    input  logic [W-1:0]  a_vk,
    input  logic [TW-1:0] a_qj,
    input  logic [TW-1:0] a_qk,
    input  logic          bus_valid,
    input  logic [TW-1:0] bus_tag,
    input  logic [W-1:0]  bus_data,
    input  logic          grant,
    output logic          busy,
    output logic          req,
    output logic [W-1:0]  res
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    slot_st_e      state, nxt;
    op_e           op_q;
    logic [W-1:0]  vj, vk;
    logic [TW-1:0] qj, qk;
    logic [CW-1:0] cnt;
    logic [W-1:0]  alu;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FREE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FREE: if (alloc)                  nxt = ST_WAIT;
            ST_WAIT: if (qj == '0 && qk == '0)   nxt = ST_EXEC;
            ST_EXEC: if (cnt == '0)              nxt = ST_DONE;
            ST_DONE: if (grant)                  nxt = ST_FREE;
        endcase
    end

    always_comb begin
        unique case (op_q)
            OP_MUL:  alu = vj * vk;
            OP_SUB:  alu = vj - vk;
            default: alu = vj + vk;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_ADD;
            vj   <= '0;
            vk   <= '0;
            qj   <= '0;
            qk   <= '0;
            cnt  <= '0;
            res  <= '0;
        end else begin
            case (state)
                ST_FREE: if (alloc) begin
                    op_q <= a_op;
                    vj   <= a_vj;
                    vk   <= a_vk;
                    qj   <= a_qj;
                    qk   <= a_qk;
                end
                ST_WAIT: begin
                    if (bus_valid && qj != '0 && qj == bus_tag) begin
                        vj <= bus_data;
                        qj <= '0;
                    end
                    if (bus_valid && qk != '0 && qk == bus_tag) begin
                        vk <= bus_data;
                        qk <= '0;
                    end
                    if (qj == '0 && qk == '0) cnt <= CW'(LAT - 1);
                end
                ST_EXEC: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else           res <= alu;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy = (state != ST_FREE);
        req  = (state == ST_DONE);
    end

    // R4: execution only ever runs on two held values
    p_exec_has_operands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC) |-> (qj == '0 && qk == '0));
    // R11: a broadcast frees the slot on the following cycle
    p_free_after_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && state == ST_DONE) |=> (state == ST_FREE));
    // R2: allocation only lands on an idle slot
    p_alloc_only_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (state == ST_FREE));

endmodule

// File: rtl/rs_sched.sv
module rs_sched
    import rs_sched_pkg::*;
#(
    parameter int W       = 16,
    parameter int NREG    = 8,
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 4,
    localparam int RW     = $clog2(NREG),
    localparam int NST    = N_ADD + N_MUL,
    localparam int TW     = $clog2(NST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [1:0]    iss_op,
    input  logic [RW-1:0] iss_dst,
    input  logic [RW-1:0] iss_src1,
    input  logic [RW-1:0] iss_src2,
    output logic          iss_ready,
    output logic          bus_valid,
    output logic [TW-1:0] bus_tag,
    output logic [W-1:0]  bus_data,
    input  logic [RW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic          rd_pending
);
    logic [W-1:0]  rf   [NREG];
    logic [TW-1:0] stat [NREG];

    logic [NST-1:0] busy, req, grant, alloc;
    logic [W-1:0]   res [NST];
    logic           fire;
    logic [TW-1:0]  new_tag;
    logic [W-1:0]   vj, vk;
    logic [TW-1:0]  qj, qk;
    op_e            op_in;

    assign op_in = op_e'(iss_op);

    // Slot selection: lowest FREE slot of the requested class
    always_comb begin
        logic found;
        found   = 1'b0;
        new_tag = '0;
        for (int i = 0; i < NST; i++) begin
            if (!busy[i] && ((i >= N_ADD) == iss_op[1]) && !found) begin
                found   = 1'b1;
                new_tag = TW'(i + 1);
            end
        end
        iss_ready = found;
        fire      = iss_valid && found;
        alloc     = '0;
        for (int i = 0; i < NST; i++)
            if (fire && new_tag == TW'(i + 1)) alloc[i] = 1'b1;
    end

    // Operand lookup with same-cycle bus bypass
    always_comb begin
        logic [TW-1:0] t1, t2;
        t1 = stat[iss_src1];
        t2 = stat[iss_src2];
        vj = rf[iss_src1];
        qj = '0;
        vk = rf[iss_src2];
        qk = '0;
        if (t1 != '0) begin
            if (bus_valid && bus_tag == t1) vj = bus_data;
            else begin vj = '0; qj = t1; end
        end
        if (t2 != '0) begin
            if (bus_valid && bus_tag == t2) vk = bus_data;
            else begin vk = '0; qk = t2; end
        end
    end

    for (genvar i = 0; i < NST; i++) begin : g_slot
        localparam int LAT = (i >= N_ADD) ? MUL_LAT : ADD_LAT;
        rs_slot #(.W(W), .TW(TW), .LAT(LAT)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .alloc    (alloc[i]),
            .a_op     (op_in),
            .a_vj     (vj),
            .a_vk     (vk),
            .a_qj     (qj),
            .a_qk     (qk),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_data (bus_data),
            .grant    (grant[i]),
            .busy     (busy[i]),
            .req      (req[i]),
            .res      (res[i])
        );
    end

    rs_prio_arb #(.N(NST)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req),
        .grant(grant)
    );

    always_comb begin
        bus_valid = |req;
        bus_tag   = '0;
        bus_data  = '0;
        for (int i = 0; i < NST; i++) begin
            if (grant[i]) begin
                bus_tag  = TW'(i + 1);
                bus_data = res[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                rf[r]   <= W'(r);
                stat[r] <= '0;
            end else begin
                if (bus_valid && stat[r] == bus_tag) begin
                    rf[r]   <= bus_data;
                    stat[r] <= '0;
                end
                if (fire && iss_dst == RW'(r)) stat[r] <= new_tag;
            end
        end
    end

    assign rd_data    = rf[rd_idx];
    assign rd_pending = (stat[rd_idx] != '0);

    // R3: an issued destination is pending on its new tag
    p_issue_marks_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (stat[$past(iss_dst)] != '0));
    // R6: a broadcast bus always names a real slot
    p_bus_tag_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0 && bus_tag <= TW'(NST)));

    for (genvar r = 0; r < NREG; r++) begin : g_reg_chk
        // R6 / R7: matching broadcast writes and clears unless re-renamed now
        p_bus_writes_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && stat[r] == bus_tag && !(fire && iss_dst == RW'(r)))
            |=> (stat[r] == '0 && rf[r] == $past(bus_data)));
    end

endmodule

// File: tb/sim_rs_sched.sv
module sim_rs_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = 2'd0;
    logic [2:0]  iss_dst = 3'd0, iss_src1 = 3'd0, iss_src2 = 3'd0;
    logic        iss_ready;
    logic        bus_valid;
    logic [2:0]  bus_tag;
    logic [15:0] bus_data;
    logic [2:0]  rd_idx = 3'd0;
    logic [15:0] rd_data;
    logic        rd_pending;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int t0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rs_sched u0 (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .bus_valid(bus_valid), .bus_tag(bus_tag),
        .bus_data(bus_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .rd_pending(rd_pending)
    );

    // Program table: {op, dst, src1, src2}; op 0 add, 1 sub, 2 mul
    localparam logic [10:0] PROG [12] = '{
        {2'd2, 3'd1, 3'd2, 3'd3},
        {2'd0, 3'd4, 3'd1, 3'd5},
        {2'd1, 3'd5, 3'd6, 3'd2},
        {2'd2, 3'd1, 3'd4, 3'd2},
        {2'd0, 3'd6, 3'd1, 3'd1},
        {2'd0, 3'd7, 3'd7, 3'd7},
        {2'd1, 3'd2, 3'd7, 3'd3},
        {2'd2, 3'd3, 3'd2, 3'd5},
        {2'd0, 3'd0, 3'd3, 3'd6},
        {2'd0, 3'd4, 3'd4, 3'd0},
        {2'd1, 3'd5, 3'd5, 3'd5},
        {2'd2, 3'd7, 3'd6, 3'd6}
    };

    logic [15:0] model [8];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        iss_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_issue(input logic [1:0] op, input logic [2:0] d,
                            input logic [2:0] a, input logic [2:0] b);
        @(negedge clk);
        iss_op = op; iss_dst = d; iss_src1 = a; iss_src2 = b;
        #0.1;
        while (!iss_ready) begin
            @(negedge clk);
        end
        iss_valid = 1'b1;
        @(posedge clk);
        #1 iss_valid = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] r, output logic [15:0] v, output logic p);
        @(negedge clk);
        rd_idx = r;
        #0.1;
        v = rd_data;
        p = rd_pending;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic        p;

        // R1: reset state
        do_reset();
        for (int r = 0; r < 8; r++) begin
            read_reg(3'(r), v, p);
            chk("R1 reg value", v, r);
            chk("R1 reg pending", p, 0);
        end
        iss_op = 2'd0; #0.1;
        chk("R1 add ready", iss_ready, 1);
        iss_op = 2'd2; #0.1;
        chk("R1 mul ready", iss_ready, 1);
        chk("R1 bus idle", bus_valid, 0);

        // Program walk: R3 R5 R7 R8 against in-order model
        for (int r = 0; r < 8; r++) model[r] = 16'(r);
        for (int i = 0; i < 12; i++) begin
            logic [1:0] op;
            logic [2:0] d, a, b;
            {op, d, a, b} = PROG[i];
            do_issue(op, d, a, b);
            case (op)
                2'd0:    model[d] = model[a] + model[b];
                2'd1:    model[d] = model[a] - model[b];
                default: model[d] = model[a] * model[b];
            endcase
        end
        repeat (80) @(posedge clk);
        for (int r = 0; r < 8; r++) begin
            read_reg(3'(r), v, p);
            chk("R3 R5 R7 R8 program reg", v, model[r]);
            chk("R6 program pending cleared", p, 0);
        end

        // Latency, stall, ignored request, free timing: R2 R4 R11
        do_reset();
        do_issue(2'd0, 3'd1, 3'd2, 3'd3);
        t0 = cyc;
        do_issue(2'd0, 3'd4, 3'd5, 3'd6);
        do_issue(2'd0, 3'd7, 3'd0, 3'd2);
        @(negedge clk);
        iss_op = 2'd0; iss_dst = 3'd0; iss_src1 = 3'd2; iss_src2 = 3'd3;
        #0.1;
        chk("R2 add class full", iss_ready, 0);
        chk("R4 no early result", bus_valid, 0);
        iss_valid = 1'b1;
        @(negedge clk);
        chk("R4 latency cycle", cyc - t0, 3);
        chk("R4 bus valid", bus_valid, 1);
        chk("R6 bus tag", bus_tag, 1);
        chk("R6 bus data", bus_data, 5);
        chk("R11 not free during broadcast", iss_ready, 0);
        iss_valid = 1'b0;
        @(negedge clk);
        chk("R11 free after broadcast", iss_ready, 1);
        chk("R6 second tag", bus_tag, 2);
        repeat (20) @(posedge clk);
        read_reg(3'd0, v, p);
        chk("R2 ignored request r0", v, 0);
        read_reg(3'd1, v, p);
        chk("R6 reg written", v, 5);

        // Priority and same-cycle bypass: R9 R10 R3
        do_reset();
        do_issue(2'd2, 3'd1, 3'd2, 3'd3);
        t0 = cyc;
        @(posedge clk); #1;
        do_issue(2'd0, 3'd4, 3'd5, 3'd6);
        read_reg(3'd1, v, p);
        chk("R3 dest pending", p, 1);
        chk("R3 old value kept", v, 1);
        while (cyc != t0 + 5) @(negedge clk);
        chk("R9 lower tag wins", bus_tag, 1);
        chk("R9 winner data", bus_data, 11);
        @(negedge clk);
        chk("R9 loser follows", bus_tag, 4);
        chk("R9 loser data", bus_data, 6);
        iss_op = 2'd0; iss_dst = 3'd7; iss_src1 = 3'd1; iss_src2 = 3'd0;
        #0.1;
        iss_valid = 1'b1;
        @(posedge clk);
        #1 iss_valid = 1'b0;
        repeat (20) @(posedge clk);
        read_reg(3'd7, v, p);
        chk("R10 bypass value", v, 6);
        chk("R10 no stale tag", p, 0);
        read_reg(3'd4, v, p);
        chk("R9 winner reg", v, 11);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule